// File: doc/BRIEF.md
# Compare-Driven PWM Set with Trip

This block drives one set of three complementary PWM pin pairs (a positive and a negative pin per channel, six pins in all) from compare-match pulses produced by an external timer. A single three-state controller (Initial, Active, Trip) is shared by all six pins. Each pin has a configured output level for each of the three states. The level a pin shows depends on the shared state and, in Active, on whether that pin's own compare pulse has arrived.

The set starts in Initial. The first compare pulse for any of its pins moves it to Active. From that point each pin switches from its Initial level to its Active level once its own compare pulse fires. The set goes back to Initial on a trip-clear pulse. It also goes back to Initial on the period compare pulse, but only when that return path is enabled. A trip input forces the set into Trip from any state and drives every pin to its safe level. Compare pulses are ignored while the set is in Trip.

The state and the per-pin compare-seen flags are registered. A pin therefore changes in the clock cycle that follows the edge at which its triggering event is sampled. The current state is also provided as a 2-bit code.

Top module: `pwm_trip_set`

## Requirements
- R1: After hardware reset (rst_n low), state_o reads 0 (Initial) and every pin drives its bit of cfg_init_lvl. A reset in any state returns the set to Initial.
- R2: In Initial, any bit of cmp_evt set without trip moves state_o to 1 (Active) at the next clock edge. Before that edge, state_o and the pins do not change.
- R3: The pin at index 2k is channel k positive and the pin at 2k+1 is channel k negative. cmp_evt[i] (compare number i+1) belongs to pin i. In Active, pin i drives cfg_act_lvl[i] only after cmp_evt[i] has been seen, including the pulse that caused the entry into Active. Until then it drives cfg_init_lvl[i].
- R4: In Active with no trip, trip-clear or enabled period event, the pins keep their levels from cycle to cycle.
- R5: A trip (trip_in high) moves state_o to 2 (Trip) from any state at the next edge, and every pin then drives cfg_trip_lvl. This holds even when a trip-clear, period or compare event arrives in the same cycle.
- R6: In Trip, compare pulses are ignored. The state stays 2 and the pins stay at their trip levels.
- R7: From Active or Trip, a trip_clr pulse without trip returns the set to Initial at the next edge. The pins then drive cfg_init_lvl and all compare-seen flags are cleared. This applies even when a compare pulse arrives in the same cycle.
- R8: From Active or Trip, period_evt returns the set to Initial only when period_rst_en is 1. With period_rst_en at 0 it has no effect.
- R9: In Initial, trip_clr and period_evt have no effect. The state stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| trip_in | input | 1 | Trip request (active high by default) |
| trip_clr | input | 1 | Trip-clear pulse, returns the set to Initial |
| period_evt | input | 1 | Period compare pulse (compare 0) |
| period_rst_en | input | 1 | Enables the return to Initial on period_evt |
| cmp_evt | input | 6 | Per-pin compare pulses; bit i is compare i+1 |
| cfg_init_lvl | input | 6 | Per-pin level in Initial |
| cfg_act_lvl | input | 6 | Per-pin level in Active after its compare |
| cfg_trip_lvl | input | 6 | Per-pin safe level in Trip |
| pwm_out | output | 6 | Pin levels; 2k = channel k positive, 2k+1 = negative |
| state_o | output | 2 | State code: 0 Initial, 1 Active, 2 Trip |

## Verification
The compare input is driven with single-bit patterns on both positive and negative pins of each channel. This shows that each pulse reaches its own pin and no other, because the configured Initial and Active levels differ per pin. Compare pulses are also sent together with trip, trip-clear and period pulses. These cases separate the priority order: trip beats everything, and trip-clear beats compare. The period pulse is sent with its enable at 0 and at 1, and from Initial, Active and Trip. This separates gating by the enable from gating by the state. A compare storm while in Trip shows that compare pulses are ignored there.

// File: rtl/pwm_set_pkg.sv
package pwm_set_pkg;

   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_ACT  = 2'd1,
      ST_TRIP = 2'd2
   } pwm_state_e;

endpackage

// File: rtl/pwm_set_fsm.sv
module pwm_set_fsm
   import pwm_set_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trip_act,
   input  logic       clr_hit,
   input  logic       per_hit,
   input  logic       any_cmp,
   output pwm_state_e state_q,
   output pwm_state_e state_d
);

   // trip outranks all; leaving Active/Trip outranks compare
   always_comb begin
      state_d = state_q;
      if (trip_act) begin
         state_d = ST_TRIP;
      end else begin
         unique case (state_q)
            ST_INIT: if (any_cmp) state_d = ST_ACT;
            ST_ACT,
            ST_TRIP: if (clr_hit || per_hit) state_d = ST_INIT;
            default: state_d = ST_INIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_INIT;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/pwm_hit_track.sv
module pwm_hit_track
   import pwm_set_pkg::*;
#(
   parameter int NUM_PINS = 6
)(
   input  logic                clk,
   input  logic                rst_n,
   input  pwm_state_e          state_d,
   input  logic [NUM_PINS-1:0] cmp_evt,
   output logic [NUM_PINS-1:0] seen_q
);

   // a flag survives only while the next state is Active
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic seen_d;
      always_comb seen_d = (state_d == ST_ACT) && (seen_q[i] || cmp_evt[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seen_q[i] <= 1'b0;
         else        seen_q[i] <= seen_d;
      end
   end

endmodule

// File: rtl/pwm_level_sel.sv
module pwm_level_sel
   import pwm_set_pkg::*;
#(
   parameter int NUM_PINS = 6
)(
   input  pwm_state_e          state_q,
   input  logic [NUM_PINS-1:0] seen_q,
   input  logic [NUM_PINS-1:0] lvl_init,
   input  logic [NUM_PINS-1:0] lvl_act,
   input  logic [NUM_PINS-1:0] lvl_trip,
   output logic [NUM_PINS-1:0] pin_lvl
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_comb begin
         unique case (state_q)
            ST_TRIP: pin_lvl[i] = lvl_trip[i];
            ST_ACT:  pin_lvl[i] = seen_q[i] ? lvl_act[i] : lvl_init[i];
            default: pin_lvl[i] = lvl_init[i];
         endcase
      end
   end

endmodule

// File: rtl/pwm_trip_set.sv
module pwm_trip_set
   import pwm_set_pkg::*;
#(
   parameter int NUM_PAIRS       = 3,
   parameter bit TRIP_ACTIVE_LOW = 1'b0,
   localparam int NUM_PINS       = 2 * NUM_PAIRS
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trip_in,
   input  logic                trip_clr,
   input  logic                period_evt,
   input  logic                period_rst_en,
   input  logic [NUM_PINS-1:0] cmp_evt,
   input  logic [NUM_PINS-1:0] cfg_init_lvl,
   input  logic [NUM_PINS-1:0] cfg_act_lvl,
   input  logic [NUM_PINS-1:0] cfg_trip_lvl,
   output logic [NUM_PINS-1:0] pwm_out,
   output logic [1:0]          state_o
);

   if (NUM_PAIRS < 1 || NUM_PAIRS > 16) begin : g_bad_pairs
      $error("pwm_trip_set: NUM_PAIRS must lie in 1..16");
   end

   logic                trip_act;
   logic                per_hit;
   pwm_state_e          st_q;
   pwm_state_e          st_d;
   logic [NUM_PINS-1:0] seen_q;

   if (TRIP_ACTIVE_LOW) begin : g_trip_low
      assign trip_act = ~trip_in;
   end else begin : g_trip_high
      assign trip_act = trip_in;
   end

   assign per_hit = period_evt & period_rst_en;

   pwm_set_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .trip_act (trip_act),
      .clr_hit  (trip_clr),
      .per_hit  (per_hit),
      .any_cmp  (|cmp_evt),
      .state_q  (st_q),
      .state_d  (st_d)
   );

   pwm_hit_track #(.NUM_PINS(NUM_PINS)) u_hits (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_d (st_d),
      .cmp_evt (cmp_evt),
      .seen_q  (seen_q)
   );

   pwm_level_sel #(.NUM_PINS(NUM_PINS)) u_sel (
      .state_q  (st_q),
      .seen_q   (seen_q),
      .lvl_init (cfg_init_lvl),
      .lvl_act  (cfg_act_lvl),
      .lvl_trip (cfg_trip_lvl),
      .pin_lvl  (pwm_out)
   );

   assign state_o = st_q;

endmodule

// File: rtl/pwm_trip_set_chk.sv
module pwm_trip_set_chk #(
   parameter int NUM_PINS = 6
)(
   input logic                clk,
   input logic                rst_n,
   input logic                trip_act,
   input logic                trip_clr,
   input logic                period_evt,
   input logic                period_rst_en,
   input logic [NUM_PINS-1:0] cmp_evt,
   input logic [NUM_PINS-1:0] cfg_init_lvl,
   input logic [NUM_PINS-1:0] cfg_trip_lvl,
   input logic [NUM_PINS-1:0] pwm_out,
   input logic [1:0]          state_o
);

   logic leave;
   assign leave = trip_clr | (period_evt & period_rst_en);

   // R1: only three legal codes
   a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'd3);

   // R1: Initial drives the Initial levels
   a_r1_init_levels: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd0 |-> pwm_out == cfg_init_lvl);

   a_r2_first_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd0 && |cmp_evt && !trip_act |=> state_o == 2'd1);

   a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd1 && cmp_evt == '0 && !trip_act && !leave
      |=> $stable(pwm_out));

   a_r5_trip_entry: assert property (@(posedge clk) disable iff (!rst_n)
      trip_act |=> state_o == 2'd2 && pwm_out == cfg_trip_lvl);

   a_r6_trip_hold: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd2 && !leave |=> state_o == 2'd2);

   a_r7_clear_exit: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'd0 && trip_clr && !trip_act |=> state_o == 2'd0);

   a_r8_period_exit: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'd0 && period_evt && period_rst_en && !trip_act
      |=> state_o == 2'd0);

   a_r9_init_stay: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd0 && cmp_evt == '0 && !trip_act |=> state_o == 2'd0);

endmodule

bind pwm_trip_set pwm_trip_set_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .trip_act      (trip_act),
   .trip_clr      (trip_clr),
   .period_evt    (period_evt),
   .period_rst_en (period_rst_en),
   .cmp_evt       (cmp_evt),
   .cfg_init_lvl  (cfg_init_lvl),
   .cfg_trip_lvl  (cfg_trip_lvl),
   .pwm_out       (pwm_out),
   .state_o       (state_o)
);

// File: tb/tb_pwm_trip_set.sv
module tb_pwm_trip_set;

   localparam logic [5:0] INIT_L = 6'b101010;
   localparam logic [5:0] ACT_L  = 6'b010101;
   localparam logic [5:0] TRIP_L = 6'b110011;

   // [17] trip [16] clr [15] period [14] enable [13:8] cmp [7:6] state [5:0] pins
   localparam int NV = 20;
   localparam logic [17:0] TBL [0:NV-1] = '{
      {4'b0000, 6'b000000, 2'd0, 6'b101010}, // R9 idle
      {4'b0100, 6'b000000, 2'd0, 6'b101010}, // R9 clear in Initial
      {4'b0011, 6'b000000, 2'd0, 6'b101010}, // R9 period in Initial
      {4'b0000, 6'b000001, 2'd1, 6'b101011}, // R2 R3 ch0 pos
      {4'b0000, 6'b000000, 2'd1, 6'b101011}, // R4 hold
      {4'b0000, 6'b000100, 2'd1, 6'b101111}, // R3 ch1 pos
      {4'b0000, 6'b100000, 2'd1, 6'b001111}, // R3 ch2 neg
      {4'b0010, 6'b000000, 2'd1, 6'b001111}, // R8 period disabled
      {4'b0011, 6'b000000, 2'd0, 6'b101010}, // R8 period enabled
      {4'b0000, 6'b000010, 2'd1, 6'b101000}, // R3 ch0 neg
      {4'b0100, 6'b000000, 2'd0, 6'b101010}, // R7 clear from Active
      {4'b0000, 6'b010000, 2'd1, 6'b111010}, // R3 ch2 pos
      {4'b1100, 6'b000011, 2'd2, 6'b110011}, // R5 trip beats clear
      {4'b0000, 6'b111111, 2'd2, 6'b110011}, // R6 compares ignored
      {4'b0010, 6'b000000, 2'd2, 6'b110011}, // R8 disabled in Trip
      {4'b0100, 6'b000001, 2'd0, 6'b101010}, // R7 clear beats compare in Trip
      {4'b1000, 6'b000001, 2'd2, 6'b110011}, // R5 trip beats compare
      {4'b0011, 6'b000000, 2'd0, 6'b101010}, // R8 period leaves Trip
      {4'b0000, 6'b001000, 2'd1, 6'b100010}, // R3 ch1 neg
      {4'b0100, 6'b000001, 2'd0, 6'b101010}  // R7 clear beats compare in Active
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trip_in = 1'b0, trip_clr = 1'b0, period_evt = 1'b0, period_rst_en = 1'b0;
   logic [5:0] cmp_evt = '0;
   logic [5:0] pwm_out;
   logic [1:0] state_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_trip_set dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .trip_in       (trip_in),
      .trip_clr      (trip_clr),
      .period_evt    (period_evt),
      .period_rst_en (period_rst_en),
      .cmp_evt       (cmp_evt),
      .cfg_init_lvl  (INIT_L),
      .cfg_act_lvl   (ACT_L),
      .cfg_trip_lvl  (TRIP_L),
      .pwm_out       (pwm_out),
      .state_o       (state_o)
   );

   task automatic check(input string req, input logic [1:0] est, input logic [5:0] eout);
      n_chk++;
      if (state_o !== est || pwm_out !== eout) begin
         n_fail++;
         $display("FAIL %s: state=%0d pins=%b expected state=%0d pins=%b",
                  req, state_o, pwm_out, est, eout);
      end
   endtask

   task automatic drive(input logic [3:0] ctl, input logic [5:0] cmp);
      @(negedge clk);
      {trip_in, trip_clr, period_evt, period_rst_en} = ctl;
      cmp_evt = cmp;
   endtask

   task automatic step(input string req, input logic [3:0] ctl, input logic [5:0] cmp,
                       input logic [1:0] est, input logic [5:0] eout);
      drive(ctl, cmp);
      @(posedge clk); #1;
      check(req, est, eout);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", 2'd0, INIT_L);
      @(negedge clk) rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         step($sformatf("vector %0d", v), TBL[v][17:14], TBL[v][13:8],
              TBL[v][7:6], TBL[v][5:0]);
      end
      drive(4'b0000, 6'b000000);

      // R2: nothing moves before the sampling edge
      drive(4'b0000, 6'b000100);
      #1;
      check("R2 before edge", 2'd0, INIT_L);
      @(posedge clk); #1;
      check("R2 after edge", 2'd1, 6'b101110);

      // R1: reset from Active
      @(negedge clk);
      cmp_evt = '0;
      rst_n = 1'b0;
      #1;
      check("R1 reset from Active", 2'd0, INIT_L);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset from Trip
      step("R5 trip from Initial", 4'b1000, 6'b000000, 2'd2, TRIP_L);
      @(negedge clk);
      trip_in = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1 reset from Trip", 2'd0, INIT_L);
      @(negedge clk) rst_n = 1'b1;

      // R4: several idle cycles in Active keep the levels
      step("R3 ch0 neg entry", 4'b0000, 6'b000010, 2'd1, 6'b101000);
      step("R4 hold 1", 4'b0000, 6'b000000, 2'd1, 6'b101000);
      step("R4 hold 2", 4'b0000, 6'b000000, 2'd1, 6'b101000);
      step("R7 clear", 4'b0100, 6'b000000, 2'd0, INIT_L);
      drive(4'b0000, 6'b000000);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule